// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small byte queue that keeps instruction bytes ready ahead of an executor. A bus fetch engine returns either a 16-bit word or a single byte per transfer on a fill stream. The executor pulls one byte at a time from a pop stream. Fetching and execution thus form a two-stage pipeline in which the fetch side runs ahead.

The block raises a plain fetch request whenever the free space can take a full bus transfer. It drops the request, leaving the bus idle, when execution falls behind and the queue cannot take one. It also keeps the address of the next byte to fetch. A flush input empties the queue in one cycle and reloads that address, for example after a taken branch.

A single parameter picks one of two variants. The wide variant has 6 bytes of storage and a 16-bit fill bus. The narrow variant has 4 bytes of storage and an 8-bit fill bus.

Fill stream rules: a transfer happens on a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` depends on `fill_two` and on the current occupancy, so the fetch engine may hold a transfer until `fill_ready` rises. Pop stream rules: a byte leaves on a cycle where `out_valid` and `out_ready` are both high. `out_byte` stays stable while `out_valid` is high and no pop is taken.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`out_valid` low), `fetch_req` is high, `fetch_addr` equals the reset address parameter (0 by default), and `fill_ready` is high.
- R2: The wide variant (`WIDE_BUS`=1) holds exactly 6 bytes and the narrow variant (`WIDE_BUS`=0) holds exactly 4. No byte beyond that capacity is ever stored.
- R3: In the wide variant, `fetch_req` is high exactly when at least 2 bytes are free. It is therefore low at 5 or 6 stored bytes.
- R4: In the narrow variant, `fetch_req` is high exactly when at least 1 byte is free.
- R5: A fill carries 2 bytes when `fill_two`=1 in the wide variant, and 1 byte otherwise. `fill_ready` is high only when at least that many bytes are free and `flush` is low. A fill offered while `fill_ready` is low is not stored and does not advance `fetch_addr`.
- R6: A 2-byte fill stores `fill_data[7:0]` ahead of `fill_data[15:8]` in pop order. A 1-byte fill stores only `fill_data[7:0]`. The narrow variant ignores `fill_two` and always takes one byte.
- R7: Bytes leave in the order they were stored, including across the wrap of the internal ring.
- R8: `out_valid` is high exactly when the queue holds at least one byte and `flush` is low. `out_byte` is then the oldest stored byte.
- R9: A fill and a pop in the same cycle change the occupancy by the number of bytes filled minus one.
- R10: While `flush` is high, on the next cycle the queue is empty and `fetch_addr` equals `flush_addr`. Fill data in the flush cycle is discarded, and a pop in that cycle is not taken.
- R11: `fetch_addr` advances by the number of bytes accepted on each fill, modulo 2^`ADDR_W`, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and reload the fetch address |
| flush_addr | input | ADDR_W | Fetch address loaded on flush |
| fetch_req | output | 1 | Free space can take a full bus transfer |
| fetch_addr | output | ADDR_W | Address of the next byte to fetch |
| fill_valid | input | 1 | Fill stream: transfer offered |
| fill_ready | output | 1 | Fill stream: transfer can be taken |
| fill_two | input | 1 | Transfer carries two bytes (wide variant only) |
| fill_data | input | 8*bus bytes | Fill bytes, low byte first |
| out_valid | output | 1 | Pop stream: byte available |
| out_ready | input | 1 | Pop stream: executor takes the byte |
| out_byte | output | 8 | Oldest stored byte |

## Verification
Corruption of the count or of a ring pointer shows at the ports within one cycle. It appears as a wrong `fetch_req` or `fill_ready` level at the thresholds, or as a byte leaving out of order. A lost or duplicated byte is caught on the next pop, because every popped value is compared against its stored order. An address counter that steps by the wrong amount, or moves on a rejected fill, shows in `fetch_addr` on the cycle after the fill. A flush that leaves residue shows as `out_valid` high on the cycle after the flush.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  function automatic int unsigned depth_of(bit wide);
    return wide ? 6 : 4;
  endfunction

  function automatic int unsigned bus_bytes_of(bit wide);
    return wide ? 2 : 1;
  endfunction

  // Ring pointer advance modulo a depth that need not be a power of two
  function automatic int unsigned ring_step(int unsigned p, int unsigned k, int unsigned d);
    int unsigned s;
    s = p + k;
    if (s >= d) s = s - d;
    return s;
  endfunction
endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
  parameter int unsigned DEPTH     = 6,
  parameter int unsigned BUS_BYTES = 2,
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned BUS_W    = 8 * BUS_BYTES
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_two,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_byte
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] lane_ptr [BUS_BYTES];
  logic             lane_en  [BUS_BYTES];

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    always_comb begin
      lane_ptr[g] = PTR_W'(pfq_pkg::ring_step(int'(wr_ptr), g, DEPTH));
      lane_en[g]  = wr_en && ((g == 0) || wr_two);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      for (int l = 0; l < BUS_BYTES; l++) begin
        if (lane_en[l] && lane_ptr[l] == PTR_W'(e)) mem[e] <= wr_data[8*l +: 8];
      end
    end
  end

  assign rd_byte = mem[rd_ptr];
endmodule

// File: rtl/pfq_occupancy.sv
module pfq_occupancy #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       push_n,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      count  <= CNT_W'(int'(count) + int'(push_n) - int'(pop));
      wr_ptr <= PTR_W'(pfq_pkg::ring_step(int'(wr_ptr), int'(push_n), DEPTH));
      if (pop) rd_ptr <= PTR_W'(pfq_pkg::ring_step(int'(rd_ptr), 1, DEPTH));
    end
  end

  a_r2_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && wr_ptr == rd_ptr));

  a_r9_net_change: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(count) == int'($past(count)) + int'($past(push_n)) - int'($past(pop)));
endmodule

// File: rtl/pfq_fetch_addr.sv
module pfq_fetch_addr #(
  parameter int unsigned ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic [1:0]        push_n,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= RESET_ADDR;
    else if (flush) addr <= flush_addr;
    else            addr <= addr + ADDR_W'(push_n);
  end

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_n == 2'd0) |=> $stable(addr));

  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> addr == $past(flush_addr));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter bit          WIDE_BUS   = 1'b1,
  parameter int unsigned ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned DEPTH     = pfq_pkg::depth_of(WIDE_BUS),
  localparam int unsigned BUS_BYTES = pfq_pkg::bus_bytes_of(WIDE_BUS),
  localparam int unsigned BUS_W     = 8 * BUS_BYTES,
  localparam int unsigned PTR_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_two,
  input  logic [BUS_W-1:0]  fill_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] free;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [1:0]       need;
  logic [1:0]       push_n;
  logic             two_eff;
  logic             accept, pop;

  if (BUS_BYTES > 1) begin : g_wide
    assign two_eff = fill_two;
  end else begin : g_narrow
    assign two_eff = 1'b0;
  end

  always_comb begin
    free       = CNT_W'(DEPTH) - count;
    need       = two_eff ? 2'd2 : 2'd1;
    fill_ready = !flush && (int'(free) >= int'(need));
    accept     = fill_valid && fill_ready;
    push_n     = accept ? need : 2'd0;
    out_valid  = !flush && (count != '0);
    pop        = out_valid && out_ready;
    fetch_req  = int'(free) >= BUS_BYTES;
  end

  pfq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(push_n), .pop(pop),
    .count(count), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  pfq_ring #(.DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES)) u_ring (
    .clk(clk), .wr_en(accept), .wr_two(two_eff), .wr_ptr(wr_ptr),
    .wr_data(fill_data), .rd_ptr(rd_ptr), .rd_byte(out_byte)
  );

  pfq_fetch_addr #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .push_n(push_n), .addr(fetch_addr)
  );

  a_r3_idle_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) > DEPTH - BUS_BYTES) |-> !fetch_req);

  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid);

  a_r5_fill_fits: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> int'(count) <= DEPTH);
endmodule

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        flush = 0, fill_valid = 0, fill_two = 0, out_ready = 0;
  logic [19:0] flush_addr = '0;
  logic [15:0] fill_data = '0;
  logic        fetch_req, fill_ready, out_valid;
  logic [19:0] fetch_addr;
  logic [7:0]  out_byte;

  logic        n_flush = 0, n_fill_valid = 0, n_fill_two = 0, n_out_ready = 0;
  logic [19:0] n_flush_addr = '0;
  logic [7:0]  n_fill_data = '0;
  logic        n_fetch_req, n_fill_ready, n_out_valid;
  logic [19:0] n_fetch_addr;
  logic [7:0]  n_out_byte;

  int checks = 0;
  int errors = 0;

  prefetch_queue u_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_two(fill_two),
    .fill_data(fill_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte)
  );

  prefetch_queue #(.WIDE_BUS(1'b0)) u_narrow (
    .clk(clk), .rst_n(rst_n), .flush(n_flush), .flush_addr(n_flush_addr),
    .fetch_req(n_fetch_req), .fetch_addr(n_fetch_addr),
    .fill_valid(n_fill_valid), .fill_ready(n_fill_ready), .fill_two(n_fill_two),
    .fill_data(n_fill_data), .out_valid(n_out_valid), .out_ready(n_out_ready),
    .out_byte(n_out_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d, input logic two);
    fill_valid = 1; fill_two = two; fill_data = d;
    tick;
    fill_valid = 0; fill_two = 0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    check(req, out_valid, 1);
    check(req, out_byte, exp);
    out_ready = 1;
    tick;
    out_ready = 0;
  endtask

  task automatic t_reset;
    fill_two = 1; #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 fetch_req", fetch_req, 1);
    check("R1 fetch_addr", fetch_addr, 0);
    check("R1 fill_ready", fill_ready, 1);
    fill_two = 0;
  endtask

  task automatic t_fill_order;
    push(16'hB2A1, 1);
    push(16'h00C3, 0);
    check("R11 addr after 2+1", fetch_addr, 3);
    pop_chk("R6 low byte first", 8'hA1);
    pop_chk("R6 high byte second", 8'hB2);
    pop_chk("R6 single byte", 8'hC3);
    check("R8 empty after pops", out_valid, 0);
  endtask

  task automatic t_full;
    push(16'hA2A1, 1);
    push(16'hA4A3, 1);
    check("R3 req at 4 stored", fetch_req, 1);
    push(16'h00A5, 0);
    check("R3 no req at 5 stored", fetch_req, 0);
    fill_two = 1; #1;
    check("R5 word not ready at 1 free", fill_ready, 0);
    fill_two = 0; #1;
    check("R5 byte ready at 1 free", fill_ready, 1);
    push(16'h00A6, 0);
    check("R3 no req when full", fetch_req, 0);
    check("R5 byte not ready when full", fill_ready, 0);
    push(16'hEEEE, 1);
    check("R5 rejected fill holds addr", fetch_addr, 9);
    pop_chk("R7 full 1", 8'hA1);
    pop_chk("R7 full 2", 8'hA2);
    pop_chk("R7 full 3", 8'hA3);
    pop_chk("R7 full 4", 8'hA4);
    pop_chk("R7 full 5", 8'hA5);
    pop_chk("R2 sixth byte", 8'hA6);
    check("R2 no seventh byte", out_valid, 0);
  endtask

  task automatic t_simul;
    push(16'h2211, 1);
    push(16'h4433, 1);
    check("R3 req at 4", fetch_req, 1);
    check("R9 oldest before overlap", out_byte, 8'h11);
    fill_valid = 1; fill_two = 1; fill_data = 16'h6655; out_ready = 1;
    tick;
    fill_valid = 0; fill_two = 0; out_ready = 0;
    check("R9 count 5 so no req", fetch_req, 0);
    pop_chk("R9 after overlap 1", 8'h22);
    pop_chk("R9 after overlap 2", 8'h33);
    pop_chk("R7 wrap 3", 8'h44);
    pop_chk("R7 wrap 4", 8'h55);
    pop_chk("R9 fifth byte", 8'h66);
    check("R9 empty", out_valid, 0);
  endtask

  task automatic t_flush;
    push(16'hCDAB, 1);
    flush = 1; flush_addr = 20'h12340;
    fill_valid = 1; fill_two = 1; fill_data = 16'h7777; out_ready = 1;
    #1;
    check("R5 not ready during flush", fill_ready, 0);
    check("R8 no valid during flush", out_valid, 0);
    tick;
    flush = 0; fill_valid = 0; fill_two = 0; out_ready = 0;
    check("R10 empty after flush", out_valid, 0);
    check("R10 addr reload", fetch_addr, 20'h12340);
    check("R10 req after flush", fetch_req, 1);
    push(16'h9988, 1);
    check("R11 addr +2", fetch_addr, 20'h12342);
    pop_chk("R10 new data 1", 8'h88);
    pop_chk("R10 new data 2", 8'h99);
    check("R10 flush data discarded", out_valid, 0);
  endtask

  task automatic t_addr_wrap;
    flush = 1; flush_addr = 20'hFFFFF;
    tick;
    flush = 0;
    push(16'h0201, 1);
    check("R11 addr wraps", fetch_addr, 20'h00001);
    pop_chk("R11 wrap data 1", 8'h01);
    pop_chk("R11 wrap data 2", 8'h02);
  endtask

  task automatic n_push(input logic [7:0] d);
    n_fill_valid = 1; n_fill_two = 1; n_fill_data = d;
    tick;
    n_fill_valid = 0; n_fill_two = 0;
  endtask

  task automatic n_pop_chk(input string req, input logic [7:0] exp);
    check(req, n_out_valid, 1);
    check(req, n_out_byte, exp);
    n_out_ready = 1;
    tick;
    n_out_ready = 0;
  endtask

  task automatic t_narrow;
    check("R4 narrow req at reset", n_fetch_req, 1);
    n_push(8'h51);
    check("R6 narrow ignores two", n_fetch_addr, 1);
    n_push(8'h52);
    n_push(8'h53);
    check("R4 narrow req at 1 free", n_fetch_req, 1);
    n_push(8'h54);
    check("R4 narrow no req when full", n_fetch_req, 0);
    check("R2 narrow full at 4", n_fill_ready, 0);
    check("R11 narrow addr", n_fetch_addr, 4);
    n_pop_chk("R7 narrow 1", 8'h51);
    n_pop_chk("R7 narrow 2", 8'h52);
    n_pop_chk("R7 narrow 3", 8'h53);
    n_pop_chk("R7 narrow 4", 8'h54);
    check("R2 narrow empty", n_out_valid, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill_order;
    t_full;
    t_simul;
    t_flush;
    t_addr_wrap;
    t_narrow;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule